// File: doc/BRIEF.md
# Reconfigurable Dual Panel Pixel FIFO

This block holds pixel words on their way from a bus DMA engine to the display datapath. In split mode it works as two separate first-in first-out queues, each 32 bits wide and 16 words deep. The upper queue serves the upper half of a dual-scan panel and the lower queue serves the lower half. Each queue has its own write port, fed by the DMA engine, and its own read port, drained by the pixel serializer. Each queue also raises a refill request toward the DMA engine when it runs low.

In joined mode, used for single-panel passive-matrix operation, both storage halves act as one queue of 32 words behind the upper ports. Words leave in the order they arrived. While joined, the lower ports are idle.

The active mode can change at run time. A change empties both queues. A write to a full queue and a read from an empty queue are both rejected, and either one latches an error flag that stays set until reset.

Top module: `dual_panel_fifo`

## Requirements
- R1: After reset both queues are empty (count 0, empty 1, full 0), both read data outputs are 0, the error flag is 0 and both refill requests are 1.
- R2: With `join_mode` = 0, each queue stores up to 16 words. Each returns its words in write order, independently of the other queue.
- R3: A write to a full queue stores nothing, leaves the count unchanged and sets the error flag.
- R4: A read from an empty queue leaves the read data output unchanged and the count at 0, and it sets the error flag.
- R5: Once set, the error flag stays 1 until reset.
- R6: With `join_mode` = 1, the upper ports form one queue of 32 words, returned in write order. `up_full` rises at 32 words.
- R7: In joined mode the lower write and read enables have no effect. The lower outputs show count 0, empty 1, full 0 and no refill request, and `lo_rd_data` keeps its value.
- R8: A refill request is 1 exactly when the queue holds at most half its capacity: 8 or fewer words in split mode, 16 or fewer in joined mode.
- R9: In any cycle where `join_mode` differs from the active mode, all port operations are ignored. Both queues become empty at that clock edge, and the new mode is active from the next cycle.
- R10: A read and a write on the same non-empty, non-full queue in one cycle both take effect, and the count is unchanged.
- R11: Count, full and empty match the number of words held, and the count never exceeds the capacity.
- R12: Read data appears on the read data output at the clock edge that accepts the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| join_mode | input | 1 | 0 = two queues, 1 = one queue of double depth |
| up_wr_en | input | 1 | Upper (or joined) queue write strobe |
| up_wr_data | input | 32 | Word to write into the upper queue |
| up_rd_en | input | 1 | Upper (or joined) queue read strobe |
| up_rd_data | output | 32 | Last word read from the upper queue |
| up_full | output | 1 | Upper queue full |
| up_empty | output | 1 | Upper queue empty |
| up_count | output | 6 | Words held in the upper queue |
| up_dma_req | output | 1 | Upper queue refill request |
| lo_wr_en | input | 1 | Lower queue write strobe (split mode only) |
| lo_wr_data | input | 32 | Word to write into the lower queue |
| lo_rd_en | input | 1 | Lower queue read strobe (split mode only) |
| lo_rd_data | output | 32 | Last word read from the lower queue |
| lo_full | output | 1 | Lower queue full |
| lo_empty | output | 1 | Lower queue empty |
| lo_count | output | 6 | Words held in the lower queue |
| lo_dma_req | output | 1 | Lower queue refill request |
| err_flag | output | 1 | Sticky overflow/underflow error |

## Verification
The interesting collision is a read and a write on the same queue in the same cycle. This matters most at the boundaries. At full, the write must be refused even though the read frees a slot. At empty, the read must be refused while the write is accepted. The bench provokes these collisions with directed sequences that fill and drain to both edges while strobing both ports together, and with random phases whose write bias repeatedly drives the level to each edge. A bench model that evaluates both operations against the queue state before the edge then judges the count, the flags, the read data and the error flag.

// File: rtl/dpf_pkg.sv
// Package: shared types for the dual panel pixel FIFO.
// Assumes nothing beyond IEEE 1800-2017.
package dpf_pkg;
    typedef enum logic {
        MODE_SPLIT  = 1'b0,
        MODE_JOINED = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/dpf_ctrl.sv
// Module: dpf_ctrl
// Pointer and occupancy controller for one queue. Capacity is DEPTH, or
// 2*DEPTH when long_mode is set. Assumes long_mode only changes in a flush
// cycle, so the pointers are always inside the active capacity.
module dpf_ctrl #(
    parameter int DEPTH = 16,
    parameter int PTR_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             enable,
    input  logic             long_mode,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic             wr_ok,
    output logic             rd_ok,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             low,
    output logic             err_pulse
);
    logic [CNT_W-1:0] cap;
    logic [PTR_W-1:0] last;
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic             active;

    // capacity and last valid slot for the active mode
    always_comb begin
        cap  = long_mode ? CNT_W'(2 * DEPTH) : CNT_W'(DEPTH);
        last = PTR_W'(cap - CNT_W'(1));
    end

    // status flags and accept decisions, all from state before the edge
    always_comb begin
        active    = enable && !flush;
        full      = enable && (count_q == cap);
        empty     = !enable || (count_q == '0);
        low       = enable && (count_q <= (cap >> 1));
        wr_ok     = active && wr_req && !full;
        rd_ok     = active && rd_req && !empty;
        err_pulse = active && ((wr_req && full) || (rd_req && empty));
    end

    // pointer and occupancy update, cleared by reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            if (wr_ok) wptr_q <= (wptr_q == last) ? '0 : wptr_q + PTR_W'(1);
            if (rd_ok) rptr_q <= (rptr_q == last) ? '0 : rptr_q + PTR_W'(1);
            count_q <= count_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
        end
    end

    assign count = count_q;
    assign wptr  = wptr_q;
    assign rptr  = rptr_q;

    p_count_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= cap);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_req && full && !rd_req) |=> (count_q == $past(count_q)));
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0));
    p_rw_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok) |=> $stable(count_q));
endmodule

// File: rtl/dpf_store.sv
// Module: dpf_store
// Shared word storage of 2*DEPTH entries with two write ports and two
// registered read ports. Assumes the two write ports never hit the same
// address in one cycle (the top gives each queue its own half in split mode).
module dpf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] waddr_a,
    input  logic [DATA_W-1:0] wdata_a,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] waddr_b,
    input  logic [DATA_W-1:0] wdata_b,
    input  logic              re_a,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic              re_b,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int WORDS = 2 * DEPTH;

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rq_a, rq_b;

    // word array writes from both ports
    always_ff @(posedge clk) begin
        if (we_a) mem[waddr_a] <= wdata_a;
        if (we_b) mem[waddr_b] <= wdata_b;
    end

    // registered read data, held when no read is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_a <= '0;
            rq_b <= '0;
        end else begin
            if (re_a) rq_a <= mem[raddr_a];
            if (re_b) rq_b <= mem[raddr_b];
        end
    end

    assign rdata_a = rq_a;
    assign rdata_b = rq_b;

    p_rd_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !re_a |=> $stable(rdata_a));
    p_rd_hold_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !re_b |=> $stable(rdata_b));
endmodule

// File: rtl/dual_panel_fifo.sv
// Module: dual_panel_fifo
// Two pixel queues for a dual-scan panel that can be joined into one queue
// of double depth. Assumes the DMA engine honours the refill requests and
// that a mode change may discard buffered words.
module dual_panel_fifo
    import dpf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(2 * DEPTH),
    localparam int CNT_W = $clog2(2 * DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              join_mode,
    input  logic              up_wr_en,
    input  logic [DATA_W-1:0] up_wr_data,
    input  logic              up_rd_en,
    output logic [DATA_W-1:0] up_rd_data,
    output logic              up_full,
    output logic              up_empty,
    output logic [CNT_W-1:0]  up_count,
    output logic              up_dma_req,
    input  logic              lo_wr_en,
    input  logic [DATA_W-1:0] lo_wr_data,
    input  logic              lo_rd_en,
    output logic [DATA_W-1:0] lo_rd_data,
    output logic              lo_full,
    output logic              lo_empty,
    output logic [CNT_W-1:0]  lo_count,
    output logic              lo_dma_req,
    output logic              err_flag
);
    fifo_mode_e       mode_q;
    logic             flush;
    logic             err_q;
    logic [1:0]       wr_ok, rd_ok, err_p, en, longm;
    logic [1:0]       wreq, rreq, fl, em, lw;
    logic [PTR_W-1:0] wp [2];
    logic [PTR_W-1:0] rp [2];
    logic [CNT_W-1:0] cnt [2];

    // a mode request differing from the active mode flushes both queues
    assign flush = (fifo_mode_e'(join_mode) != mode_q);

    // per-queue hookup: upper always runs, lower only in split mode
    always_comb begin
        wreq  = {lo_wr_en, up_wr_en};
        rreq  = {lo_rd_en, up_rd_en};
        en    = {mode_q == MODE_SPLIT, 1'b1};
        longm = {1'b0, mode_q == MODE_JOINED};
    end

    generate
        for (genvar g = 0; g < 2; g++) begin : g_q
            dpf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
                .clk(clk), .rst_n(rst_n), .flush(flush), .enable(en[g]),
                .long_mode(longm[g]), .wr_req(wreq[g]), .rd_req(rreq[g]),
                .wr_ok(wr_ok[g]), .rd_ok(rd_ok[g]), .wptr(wp[g]), .rptr(rp[g]),
                .count(cnt[g]), .full(fl[g]), .empty(em[g]), .low(lw[g]),
                .err_pulse(err_p[g])
            );
        end
    endgenerate

    // lower queue lives in the upper half of storage; joined mode spans all
    dpf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_a(wr_ok[0]), .waddr_a(wp[0]), .wdata_a(up_wr_data),
        .we_b(wr_ok[1]), .waddr_b(PTR_W'(DEPTH) + wp[1]), .wdata_b(lo_wr_data),
        .re_a(rd_ok[0]), .raddr_a(rp[0]),
        .re_b(rd_ok[1]), .raddr_b(PTR_W'(DEPTH) + rp[1]),
        .rdata_a(up_rd_data), .rdata_b(lo_rd_data)
    );

    // active mode register and sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SPLIT;
            err_q  <= 1'b0;
        end else begin
            mode_q <= fifo_mode_e'(join_mode);
            err_q  <= err_q || (|err_p);
        end
    end

    assign up_full    = fl[0];
    assign up_empty   = em[0];
    assign up_count   = cnt[0];
    assign up_dma_req = lw[0];
    assign lo_full    = fl[1];
    assign lo_empty   = em[1];
    assign lo_count   = cnt[1];
    assign lo_dma_req = lw[1];
    assign err_flag   = err_q;

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    p_joined_lower_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_JOINED) |-> (lo_count == '0 && lo_empty && !lo_full && !lo_dma_req));
    p_mode_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (mode_q == fifo_mode_e'($past(join_mode))));
    p_no_dual_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_JOINED) |-> !wr_ok[1]);
endmodule

// File: tb/dual_panel_fifo_tb.sv
module dual_panel_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        join_mode = 1'b0;
    logic        up_wr_en = 1'b0, up_rd_en = 1'b0, lo_wr_en = 1'b0, lo_rd_en = 1'b0;
    logic [31:0] up_wr_data = '0, lo_wr_data = '0;
    logic [31:0] up_rd_data, lo_rd_data;
    logic        up_full, up_empty, up_dma_req, lo_full, lo_empty, lo_dma_req, err_flag;
    logic [5:0]  up_count, lo_count;

    int total = 0;
    int fails = 0;
    bit done = 0;
    string ph = "R1";

    // bench model state
    logic [31:0] q0[$];
    logic [31:0] q1[$];
    bit          m_mode = 0;
    bit          m_err = 0;
    logic [31:0] m_rd0 = '0, m_rd1 = '0;
    int          cap0;
    bit          f0, e0, f1, e1;

    always #10 clk = ~clk;

    dual_panel_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .join_mode(join_mode),
        .up_wr_en(up_wr_en), .up_wr_data(up_wr_data), .up_rd_en(up_rd_en),
        .up_rd_data(up_rd_data), .up_full(up_full), .up_empty(up_empty),
        .up_count(up_count), .up_dma_req(up_dma_req),
        .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data), .lo_rd_en(lo_rd_en),
        .lo_rd_data(lo_rd_data), .lo_full(lo_full), .lo_empty(lo_empty),
        .lo_count(lo_count), .lo_dma_req(lo_dma_req), .err_flag(err_flag)
    );

    // reference model: both operations judged on the state before the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q0.delete(); q1.delete();
            m_mode = 0; m_err = 0; m_rd0 = '0; m_rd1 = '0;
        end else if (join_mode != m_mode) begin
            q0.delete(); q1.delete();
            m_mode = join_mode;
        end else begin
            cap0 = m_mode ? 32 : 16;
            f0 = (q0.size() == cap0); e0 = (q0.size() == 0);
            f1 = (q1.size() == 16);   e1 = (q1.size() == 0);
            if (up_rd_en) begin
                if (e0) m_err = 1; else m_rd0 = q0.pop_front();
            end
            if (up_wr_en) begin
                if (f0) m_err = 1; else q0.push_back(up_wr_data);
            end
            if (!m_mode) begin
                if (lo_rd_en) begin
                    if (e1) m_err = 1; else m_rd1 = q1.pop_front();
                end
                if (lo_wr_en) begin
                    if (f1) m_err = 1; else q1.push_back(lo_wr_data);
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s (phase %s): actual %0h expected %0h", req, what, ph, act, exp);
        end
    endtask

    task automatic compare_all();
        int c0 = m_mode ? 32 : 16;
        chk("R11", "up_count", 32'(up_count), 32'(q0.size()));
        chk("R11", "up_full",  32'(up_full),  32'(q0.size() == c0));
        chk("R11", "up_empty", 32'(up_empty), 32'(q0.size() == 0));
        chk("R8",  "up_dma_req", 32'(up_dma_req), 32'(q0.size() <= c0 / 2));
        chk(m_mode ? "R6" : "R2", "up_rd_data R12", up_rd_data, m_rd0);
        if (m_mode) begin
            chk("R7", "lo_count", 32'(lo_count), 0);
            chk("R7", "lo_full",  32'(lo_full), 0);
            chk("R7", "lo_empty", 32'(lo_empty), 1);
            chk("R7", "lo_dma_req", 32'(lo_dma_req), 0);
            chk("R7", "lo_rd_data", lo_rd_data, m_rd1);
        end else begin
            chk("R11", "lo_count", 32'(lo_count), 32'(q1.size()));
            chk("R11", "lo_full",  32'(lo_full),  32'(q1.size() == 16));
            chk("R11", "lo_empty", 32'(lo_empty), 32'(q1.size() == 0));
            chk("R8",  "lo_dma_req", 32'(lo_dma_req), 32'(q1.size() <= 8));
            chk("R2",  "lo_rd_data R12", lo_rd_data, m_rd1);
        end
        chk("R5", "err_flag", 32'(err_flag), 32'(m_err));
    endtask

    // drive one cycle of inputs at the falling edge, check at the next one
    task automatic step(bit jm, bit uw, logic [31:0] ud, bit ur,
                        bit lw, logic [31:0] ld, bit lr);
        join_mode = jm;
        up_wr_en = uw; up_wr_data = ud; up_rd_en = ur;
        lo_wr_en = lw; lo_wr_data = ld; lo_rd_en = lr;
        @(negedge clk);
        compare_all();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, with literal expectations as well
        ph = "R1";
        compare_all();
        chk("R1", "reset up_dma_req", 32'(up_dma_req), 1);
        chk("R1", "reset up_empty", 32'(up_empty), 1);
        chk("R1", "reset err_flag", 32'(err_flag), 0);
        chk("R1", "reset lo_rd_data", lo_rd_data, 0);

        // R2: fill both queues in split mode with distinct patterns
        ph = "R2 fill";
        for (int i = 0; i < 16; i++) step(0, 1, 32'hA000 + i, 0, 1, 32'hB000 + i, 0);
        chk("R2", "upper full after 16", 32'(up_full), 1);
        // R3: overflow on both ports; R10: read+write at full refuses the write
        ph = "R3 overflow";
        step(0, 1, 32'hDEAD, 0, 1, 32'hBEEF, 0);
        chk("R3", "err after overflow", 32'(err_flag), 1);
        ph = "R10 rw at full";
        step(0, 1, 32'hCAFE, 1, 1, 32'hF00D, 1);
        // R10: read and write together mid-level
        ph = "R10 rw mid";
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, 1);
        for (int i = 0; i < 5; i++) step(0, 1, 32'hC000 + i, 1, 1, 32'hD000 + i, 1);
        // R4: drain and read past empty; R10 read+write at empty
        ph = "R4 drain";
        for (int i = 0; i < 18; i++) step(0, 0, 0, 1, 0, 0, 1);
        chk("R4", "up_rd_data held", up_rd_data, m_rd0);
        ph = "R10 rw at empty";
        step(0, 1, 32'h1234, 1, 1, 32'h5678, 1);
        step(0, 0, 0, 1, 0, 0, 1);

        // R9: switch to joined while both queues hold words
        ph = "R9 to joined";
        for (int i = 0; i < 5; i++) step(0, 1, 32'hE000 + i, 0, 1, 32'hE100 + i, 0);
        step(1, 1, 32'h9999, 1, 1, 32'h8888, 1);
        chk("R9", "up_count after switch", 32'(up_count), 0);

        // R6 with R7: fill 32 words while strobing the idle lower ports
        ph = "R6 joined fill";
        for (int i = 0; i < 32; i++) step(1, 1, 32'h6000 + i, 0, 1, 32'h7000 + i, i[0]);
        chk("R6", "joined full at 32", 32'(up_full), 1);
        ph = "R3 joined overflow";
        step(1, 1, 32'h6666, 0, 0, 0, 0);
        ph = "R6 joined drain";
        for (int i = 0; i < 33; i++) step(1, 0, 0, 1, 1, 32'h7777, 1);

        // R9: switch back to split
        ph = "R9 to split";
        step(1, 1, 32'h4000, 0, 0, 0, 0);
        step(0, 1, 32'h4001, 1, 1, 32'h4002, 1);

        // random phases with shifting write bias, rare mode flips
        ph = "random";
        for (int blk = 0; blk < 10; blk++) begin
            int wb = (blk % 2 == 0) ? 75 : 25;
            bit jm = (blk % 4 >= 2);
            for (int i = 0; i < 300; i++) begin
                step(jm,
                     ($urandom % 100) < wb, $urandom, ($urandom % 100) < (100 - wb),
                     ($urandom % 100) < wb, $urandom, ($urandom % 100) < (100 - wb));
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule